// File: doc/BRIEF.md
# Wake-on-LAN Frame Detector

This block sits beside an Ethernet receive path and watches the byte stream a MAC hands upward. It flags a wake event when a frame qualifies under any of four independently enabled sources. The sources are a magic packet for the station, an ARP request aimed at the station's IP address, a destination equal to a dedicated match address, and a multicast destination that hits a 64-entry hash table. The station MAC, the IP address, the match address and the hash table are plain configuration inputs.

Each source owns a sticky status bit. A bit is set only when the last byte of a frame arrives together with a good-CRC indication, and software clears it with a write-one-to-clear strobe. A single wake output is the OR of the status bits. Addresses are carried with the first byte on the wire in bits [7:0]. The IP address is carried in network order, with its first byte in bits [31:24].

Top module: `wol_detect`

## Requirements
- R1: While reset is asserted and in the cycle after it, `wake_status` is 0 and `wake_out` is 0.
- R2: Status bit 0 is set when the frame contains, at byte offset 14 or later, six 0xFF bytes followed at once by sixteen back-to-back copies of `cfg_mac`. Byte j of each copy is `cfg_mac[8j+7:8j]`. This holds for a station address that contains no 0xFF byte.
- R3: Status bit 1 is set when bytes 12..13 are 0x08,0x06, bytes 20..21 are 0x00,0x01, and bytes 38..41 equal `cfg_ip[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` in that order.
- R4: Status bit 2 is set when bytes 0..5 of the frame equal `cfg_match_addr`, with byte j compared to bits [8j+7:8j].
- R5: Status bit 3 is set when bit 0 of frame byte 0 is 1 and `cfg_hash_table[h]` is 1. Here h[i] is the XOR of every destination bit k with k mod 6 = i, and bit k is bit (k mod 8) of byte k/8. Unicast destinations never set this bit.
- R6: Status bits change to 1 only on the clock edge that takes a frame's last byte (`rx_valid` and `rx_eof` both high) while `rx_crc_ok` is high. With a bad CRC the status is unchanged.
- R7: A source whose `src_enable` bit is 0 at the end of the frame does not set its status bit. Enable bit n gates status bit n.
- R8: A 1 on `status_clear[n]` clears status bit n on the next edge. If the same edge sets bit n from a qualifying frame end, the bit ends up set.
- R9: `wake_out` is 1 exactly when at least one `wake_status` bit is 1.
- R10: Cycles with `rx_valid` low are ignored entirely, whatever `rx_sof`, `rx_eof` and `rx_data` carry. A frame may be spread over cycles with gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Current byte is the first of a frame |
| rx_eof | input | 1 | Current byte is the last of a frame |
| rx_crc_ok | input | 1 | Frame CRC good, sampled with the last byte |
| rx_data | input | 8 | Receive byte |
| cfg_mac | input | 48 | Station MAC address, first wire byte in [7:0] |
| cfg_ip | input | 32 | Station IP address, network order |
| cfg_match_addr | input | 48 | Dedicated destination match address |
| cfg_hash_table | input | 64 | Multicast hash table |
| src_enable | input | 4 | Per-source enable: 0 magic, 1 ARP, 2 match, 3 hash |
| status_clear | input | 4 | Write-one-to-clear strobe per status bit |
| wake_status | output | 4 | Sticky per-source wake status |
| wake_out | output | 1 | OR of the status bits |

## Verification
A clear strobe and a frame-end set can land on the same edge. The bench provokes this by driving `status_clear` on the last-byte cycle of a qualifying frame, both on the bit that frame sets and on a different, already-set bit. The set bit must survive and the other bit must drop. Random frames also apply random clear masks on their last byte. A behavioural model, fed from byte queues, predicts every status bit on every clock.

// File: rtl/wol_pkg.sv
package wol_pkg;
    localparam int IDX_W       = 11;
    localparam int ADDR_W      = 48;
    localparam int ADDR_BYTES  = ADDR_W / 8;
    localparam int IP_W        = 32;
    localparam int HASH_W      = 64;
    localparam int HASH_IDX_W  = $clog2(HASH_W);
    localparam int NUM_SRC     = 4;

    localparam int SRC_MAGIC = 0;
    localparam int SRC_ARP   = 1;
    localparam int SRC_MATCH = 2;
    localparam int SRC_HASH  = 3;

    localparam logic [IDX_W-1:0] POS_PAYLOAD = IDX_W'(14);
    localparam logic [IDX_W-1:0] POS_TYPE    = IDX_W'(12);
    localparam logic [IDX_W-1:0] POS_OPCODE  = IDX_W'(20);
    localparam logic [IDX_W-1:0] POS_TPA     = IDX_W'(38);
    localparam logic [IDX_W-1:0] IDX_MAX     = '1;

    localparam logic [15:0] ETYPE_ARP  = 16'h0806;
    localparam logic [15:0] ARP_OP_REQ = 16'h0001;

    localparam int MAGIC_SYNC = 6;
    localparam int MAGIC_REPS = 16;

    typedef struct packed {
        logic             take;
        logic             first;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } rx_beat_t;

    typedef enum logic [1:0] {
        MG_HUNT,
        MG_MATCH,
        MG_DONE
    } magic_state_e;

    function automatic logic [7:0] addr_byte(input logic [ADDR_W-1:0] a, input logic [2:0] i);
        return a[8*i +: 8];
    endfunction

    function automatic logic [HASH_IDX_W-1:0] hash_fold(input logic [ADDR_W-1:0] a);
        logic [HASH_IDX_W-1:0] r;
        r = '0;
        for (int k = 0; k < ADDR_W; k++) begin
            r[k % HASH_IDX_W] = r[k % HASH_IDX_W] ^ a[k];
        end
        return r;
    endfunction
endpackage

// File: rtl/wol_magic.sv
module wol_magic
    import wol_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_beat_t          beat,
    input  logic [ADDR_W-1:0] mac,
    output logic              hit
);
    localparam int RUN_W = $clog2(MAGIC_SYNC + 1);
    localparam int REP_W = $clog2(MAGIC_REPS);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(MAGIC_SYNC);
    localparam logic [REP_W-1:0] REP_LAST = REP_W'(MAGIC_REPS - 1);
    localparam logic [2:0]       PTR_LAST = 3'(ADDR_BYTES - 1);

    magic_state_e     st_q, st_c, st_n;
    logic [RUN_W-1:0] run_q, run_c, run_n;
    logic [2:0]       ptr_q, ptr_c, ptr_n;
    logic [REP_W-1:0] rep_q, rep_c, rep_n;
    logic [7:0]       want;

    always_comb begin
        if (beat.first) begin
            st_c = MG_HUNT; run_c = '0; ptr_c = '0; rep_c = '0;
        end else begin
            st_c = st_q; run_c = run_q; ptr_c = ptr_q; rep_c = rep_q;
        end
        want  = addr_byte(mac, ptr_c);
        st_n  = st_c; run_n = run_c; ptr_n = ptr_c; rep_n = rep_c;
        if (beat.take && beat.idx >= POS_PAYLOAD) begin
            case (st_c)
                MG_HUNT: begin
                    if (beat.data == 8'hFF) begin
                        if (run_c != RUN_FULL) run_n = run_c + 1'b1;
                    end else if (run_c == RUN_FULL && beat.data == want) begin
                        st_n = MG_MATCH; ptr_n = 3'd1; rep_n = '0; run_n = '0;
                    end else begin
                        run_n = '0;
                    end
                end
                MG_MATCH: begin
                    if (beat.data == want) begin
                        if (ptr_c == PTR_LAST) begin
                            ptr_n = '0;
                            if (rep_c == REP_LAST) st_n = MG_DONE;
                            else rep_n = rep_c + 1'b1;
                        end else begin
                            ptr_n = ptr_c + 3'd1;
                        end
                    end else begin
                        st_n = MG_HUNT; ptr_n = '0; rep_n = '0;
                        run_n = (beat.data == 8'hFF) ? RUN_W'(1) : '0;
                    end
                end
                default: ;
            endcase
        end
        hit = (st_n == MG_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= MG_HUNT; run_q <= '0; ptr_q <= '0; rep_q <= '0;
        end else if (beat.take) begin
            st_q <= st_n; run_q <= run_n; ptr_q <= ptr_n; rep_q <= rep_n;
        end
    end

    // R2: once the pattern is complete it stays found until a new frame starts
    assert_magic_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == MG_DONE && beat.take && !beat.first) |=> (st_q == MG_DONE));
endmodule

// File: rtl/wol_arp.sv
module wol_arp
    import wol_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  rx_beat_t        beat,
    input  logic [IP_W-1:0] ip,
    output logic            hit
);
    logic       ok_q, ok_c, ok_n;
    logic       seen_q, seen_c, seen_n;
    logic       chk;
    logic [7:0] expect_byte;

    always_comb begin
        ok_c   = beat.first ? 1'b1 : ok_q;
        seen_c = beat.first ? 1'b0 : seen_q;
        chk    = 1'b1;
        expect_byte = 8'h00;
        case (beat.idx)
            POS_TYPE:                 expect_byte = ETYPE_ARP[15:8];
            POS_TYPE + IDX_W'(1):     expect_byte = ETYPE_ARP[7:0];
            POS_OPCODE:               expect_byte = ARP_OP_REQ[15:8];
            POS_OPCODE + IDX_W'(1):   expect_byte = ARP_OP_REQ[7:0];
            POS_TPA:                  expect_byte = ip[31:24];
            POS_TPA + IDX_W'(1):      expect_byte = ip[23:16];
            POS_TPA + IDX_W'(2):      expect_byte = ip[15:8];
            POS_TPA + IDX_W'(3):      expect_byte = ip[7:0];
            default:                  chk = 1'b0;
        endcase
        ok_n   = ok_c & ~(beat.take & chk & (beat.data != expect_byte));
        seen_n = seen_c | (beat.take && beat.idx == POS_TPA + IDX_W'(3));
        hit    = ok_n & seen_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q <= 1'b1; seen_q <= 1'b0;
        end else if (beat.take) begin
            ok_q <= ok_n; seen_q <= seen_n;
        end
    end
endmodule

// File: rtl/wol_addr.sv
module wol_addr
    import wol_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_beat_t          beat,
    input  logic [ADDR_W-1:0] match_addr,
    input  logic [HASH_W-1:0] hash_table,
    output logic              match_hit,
    output logic              hash_hit
);
    logic [ADDR_W-1:0] da_q, da_n;
    logic              have_q, have_n;

    always_comb begin
        da_n   = da_q;
        have_n = beat.first ? 1'b0 : have_q;
        for (int b = 0; b < ADDR_BYTES; b++) begin
            if (beat.take && beat.idx == IDX_W'(b)) da_n[8*b +: 8] = beat.data;
        end
        if (beat.take && beat.idx == IDX_W'(ADDR_BYTES - 1)) have_n = 1'b1;
        match_hit = have_n && (da_n == match_addr);
        hash_hit  = have_n && da_n[0] && hash_table[hash_fold(da_n)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            da_q <= '0; have_q <= 1'b0;
        end else if (beat.take) begin
            da_q <= da_n; have_q <= have_n;
        end
    end
endmodule

// File: rtl/wol_detect.sv
module wol_detect
    import wol_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic               rx_sof,
    input  logic               rx_eof,
    input  logic               rx_crc_ok,
    input  logic [7:0]         rx_data,
    input  logic [ADDR_W-1:0]  cfg_mac,
    input  logic [IP_W-1:0]    cfg_ip,
    input  logic [ADDR_W-1:0]  cfg_match_addr,
    input  logic [HASH_W-1:0]  cfg_hash_table,
    input  logic [NUM_SRC-1:0] src_enable,
    input  logic [NUM_SRC-1:0] status_clear,
    output logic [NUM_SRC-1:0] wake_status,
    output logic               wake_out
);
    logic               in_frame_q;
    logic [IDX_W-1:0]   idx_q;
    rx_beat_t           beat;
    logic [NUM_SRC-1:0] hits, ev_set, status_q;
    logic               commit;

    always_comb begin
        beat.take  = rx_valid && (rx_sof || in_frame_q);
        beat.first = rx_valid && rx_sof;
        beat.idx   = rx_sof ? '0 : idx_q;
        beat.data  = rx_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            idx_q      <= '0;
        end else if (beat.take) begin
            in_frame_q <= !rx_eof;
            idx_q      <= (beat.idx == IDX_MAX) ? beat.idx : beat.idx + 1'b1;
        end
    end

    wol_magic u_magic (.clk(clk), .rst(rst), .beat(beat), .mac(cfg_mac), .hit(hits[SRC_MAGIC]));
    wol_arp   u_arp   (.clk(clk), .rst(rst), .beat(beat), .ip(cfg_ip), .hit(hits[SRC_ARP]));
    wol_addr  u_addr  (.clk(clk), .rst(rst), .beat(beat), .match_addr(cfg_match_addr),
                       .hash_table(cfg_hash_table), .match_hit(hits[SRC_MATCH]),
                       .hash_hit(hits[SRC_HASH]));

    assign commit = beat.take && rx_eof && rx_crc_ok;
    assign ev_set = commit ? (hits & src_enable) : '0;

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~status_clear) | ev_set;
    end

    assign wake_status = status_q;
    assign wake_out    = |status_q;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (status_q == '0));

    assert_set_only_on_good_end_R6: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ((status_q & ~$past(status_q)) == '0));

    assert_enable_gates_R7: assert property (@(posedge clk) disable iff (rst)
        commit |=> ((status_q & ~$past(status_q) & ~$past(src_enable)) == '0));

    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (rst)
        ((status_clear & ~ev_set) != '0) |=> ((status_q & $past(status_clear & ~ev_set)) == '0));
endmodule

// File: tb/wol_detect_test.sv
`timescale 1ns/1ps
module wol_detect_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc_ok = 0;
    logic [7:0]  rx_data = 0;
    logic [47:0] cfg_mac = 48'h554433221102;
    logic [31:0] cfg_ip = 32'hC0A8010A;
    logic [47:0] cfg_match_addr = 48'h605040302010;
    logic [63:0] cfg_hash_table = 64'h0;
    logic [3:0]  src_enable = 4'hF;
    logic [3:0]  status_clear = 4'h0;
    logic [3:0]  wake_status;
    logic        wake_out;

    localparam logic [47:0] MCAST = 48'hFB00005E0001;
    localparam logic [47:0] OTHER = 48'h0C0B0A090806;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    bit m_in_frame = 0;
    logic [3:0] exp_status = 4'h0;

    always #2 clk = ~clk;

    wol_detect uut (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic logic [5:0] fold6(input logic [47:0] a);
        logic [5:0] r = 0;
        for (int k = 0; k < 48; k++) r[k % 6] = r[k % 6] ^ a[k];
        return r;
    endfunction

    function automatic logic [3:0] model_events();
        logic [3:0] e = 0;
        logic [47:0] da = 0;
        int n = rxq.size();
        if (n >= 6) begin
            for (int j = 0; j < 6; j++) da[8*j +: 8] = rxq[j];
            e[2] = (da == cfg_match_addr);
            e[3] = rxq[0][0] && cfg_hash_table[fold6(da)];
        end
        if (n >= 42)
            e[1] = rxq[12] == 8'h08 && rxq[13] == 8'h06 && rxq[20] == 8'h00 && rxq[21] == 8'h01 &&
                   rxq[38] == cfg_ip[31:24] && rxq[39] == cfg_ip[23:16] &&
                   rxq[40] == cfg_ip[15:8] && rxq[41] == cfg_ip[7:0];
        for (int s = 14; s + 102 <= n; s++) begin
            bit ok = 1;
            for (int k = 0; k < 6; k++) if (rxq[s+k] != 8'hFF) ok = 0;
            for (int j = 0; j < 96; j++) if (rxq[s+6+j] != cfg_mac[8*(j%6) +: 8]) ok = 0;
            if (ok) e[0] = 1;
        end
        return e;
    endfunction

    task automatic cycle(input logic v, input logic sof, input logic eof, input logic crc,
                         input logic [7:0] d, input logic [3:0] clr);
        logic [3:0] ev = 0;
        bit take;
        rx_valid = v; rx_sof = sof; rx_eof = eof; rx_crc_ok = crc; rx_data = d; status_clear = clr;
        @(posedge clk);
        take = v && (sof || m_in_frame);
        if (take) begin
            if (sof) rxq.delete();
            rxq.push_back(d);
            m_in_frame = !eof;
            if (eof && crc) ev = model_events() & src_enable;
        end
        exp_status = (exp_status & ~clr) | ev;
        @(negedge clk);
        check(wake_status[0] == exp_status[0], "R2 magic bit", wake_status, exp_status);
        check(wake_status[1] == exp_status[1], "R3 arp bit", wake_status, exp_status);
        check(wake_status[2] == exp_status[2], "R4 match bit", wake_status, exp_status);
        check(wake_status[3] == exp_status[3], "R5 hash bit", wake_status, exp_status);
        check(wake_out == (exp_status != 0), "R9 wake_out", wake_out, exp_status != 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 8'h00, 4'h0);
    endtask

    task automatic clear_all();
        cycle(0, 0, 0, 0, 8'h00, 4'hF);
    endtask

    // gap > 0 inserts an invalid junk cycle after every gap bytes (R10)
    task automatic send(input bit crc, input int gap, input logic [3:0] clr_end);
        int n = txq.size();
        for (int i = 0; i < n; i++) begin
            cycle(1, i == 0, i == n - 1, crc, txq[i], (i == n - 1) ? clr_end : 4'h0);
            if (gap > 0 && i != n - 1 && (i % gap) == gap - 1)
                cycle(0, 1, 1, 1, 8'hFF, 4'h0);
        end
        idle(2);
    endtask

    task automatic base(input logic [47:0] da, input logic [15:0] etype);
        txq.delete();
        for (int j = 0; j < 6; j++) txq.push_back(da[8*j +: 8]);
        for (int j = 0; j < 6; j++) txq.push_back(8'h30 + 8'(j));
        txq.push_back(etype[15:8]); txq.push_back(etype[7:0]);
    endtask

    task automatic make_magic(input int reps);
        base(OTHER, 16'h0842);
        txq.push_back(8'h11); txq.push_back(8'hFF); txq.push_back(8'h22);
        for (int k = 0; k < 6; k++) txq.push_back(8'hFF);
        for (int j = 0; j < reps * 6; j++) txq.push_back(cfg_mac[8*(j%6) +: 8]);
        for (int k = 0; k < 4; k++) txq.push_back(8'h5A);
    endtask

    task automatic make_arp(input logic [15:0] op, input logic [31:0] tip);
        base(48'hFFFFFFFFFFFF, 16'h0806);
        txq.push_back(8'h00); txq.push_back(8'h01); txq.push_back(8'h08); txq.push_back(8'h00);
        txq.push_back(8'h06); txq.push_back(8'h04);
        txq.push_back(op[15:8]); txq.push_back(op[7:0]);
        for (int k = 0; k < 10; k++) txq.push_back(8'h40 + 8'(k));
        for (int k = 0; k < 6; k++) txq.push_back(8'h00);
        txq.push_back(tip[31:24]); txq.push_back(tip[23:16]); txq.push_back(tip[15:8]); txq.push_back(tip[7:0]);
        while (txq.size() < 64) txq.push_back(8'h00);
    endtask

    task automatic make_short(input logic [47:0] da);
        base(da, 16'h0800);
        while (txq.size() < 60) txq.push_back(8'h77);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(wake_status == 4'h0, "R1 status after reset", wake_status, 0);
        check(wake_out == 1'b0, "R1 wake after reset", wake_out, 0);
        rst = 1'b0;
        idle(2);
        check(wake_status == 4'h0, "R1 status held", wake_status, 0);

        make_magic(16); send(1, 0, 4'h0);
        check(wake_status[0] == 1'b1, "R2 magic detected", wake_status, 1);
        check(wake_out == 1'b1, "R9 wake raised", wake_out, 1);
        clear_all();
        check(wake_status == 4'h0, "R8 clear", wake_status, 0);

        make_magic(15); send(1, 0, 4'h0);
        check(wake_status[0] == 1'b0, "R2 fifteen copies", wake_status, 0);
        make_magic(16); send(0, 0, 4'h0);
        check(wake_status == 4'h0, "R6 bad crc ignored", wake_status, 0);
        src_enable = 4'hE;
        make_magic(16); send(1, 0, 4'h0);
        check(wake_status[0] == 1'b0, "R7 disabled source", wake_status, 0);
        src_enable = 4'hF;
        make_magic(16); send(1, 3, 4'h0);
        check(wake_status[0] == 1'b1, "R10 gaps ignored", wake_status, 1);
        clear_all();

        make_arp(16'h0001, cfg_ip); send(1, 0, 4'h0);
        check(wake_status[1] == 1'b1, "R3 arp to own ip", wake_status[1], 1);
        clear_all();
        make_arp(16'h0001, cfg_ip ^ 32'h1); send(1, 0, 4'h0);
        check(wake_status[1] == 1'b0, "R3 arp other ip", wake_status[1], 0);
        make_arp(16'h0002, cfg_ip); send(1, 0, 4'h0);
        check(wake_status[1] == 1'b0, "R3 arp reply", wake_status[1], 0);
        clear_all();

        make_short(cfg_match_addr); send(1, 0, 4'h0);
        check(wake_status[2] == 1'b1, "R4 match address", wake_status[2], 1);
        clear_all();
        make_short(cfg_match_addr ^ 48'h010000000000); send(1, 0, 4'h0);
        check(wake_status[2] == 1'b0, "R4 last byte differs", wake_status[2], 0);

        cfg_hash_table = 64'h1 << fold6(MCAST);
        make_short(MCAST); send(1, 0, 4'h0);
        check(wake_status[3] == 1'b1, "R5 hash hit", wake_status[3], 1);
        clear_all();
        cfg_hash_table = ~(64'h1 << fold6(MCAST));
        make_short(MCAST); send(1, 0, 4'h0);
        check(wake_status[3] == 1'b0, "R5 table bit clear", wake_status[3], 0);
        clear_all();
        cfg_hash_table = '1;
        make_short(OTHER); send(1, 0, 4'h0);
        check(wake_status[3] == 1'b0, "R5 unicast never hashes", wake_status[3], 0);
        cfg_hash_table = 64'h0;
        clear_all();

        make_magic(16); send(1, 0, 4'h0);
        make_magic(16); send(1, 0, 4'h1);
        check(wake_status[0] == 1'b1, "R8 set wins over clear", wake_status[0], 1);
        make_short(cfg_match_addr); send(1, 0, 4'h0);
        make_magic(16); send(1, 0, 4'h4);
        check(wake_status == 4'h1, "R8 other bit cleared same edge", wake_status, 1);
        clear_all();

        for (int f = 0; f < 40; f++) begin
            int kind = $urandom_range(0, 4);
            src_enable = 4'($urandom);
            cfg_hash_table = {$urandom, $urandom};
            case (kind)
                0: make_magic($urandom_range(15, 16));
                1: make_arp(16'($urandom_range(1, 2)), $urandom_range(0, 1) ? cfg_ip : 32'($urandom));
                2: make_short(cfg_match_addr);
                3: make_short(MCAST);
                default: begin
                    base({$urandom, 16'($urandom)}, 16'($urandom));
                    for (int k = 0; k < $urandom_range(0, 60); k++) txq.push_back(8'($urandom));
                end
            endcase
            send($urandom_range(0, 3) != 0, $urandom_range(0, 5), 4'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule